// File: doc/BRIEF.md
# Segmented Deterministic Test Pattern Generator

This block is a built-in source of deterministic test vectors. The output vector is split into equal-width column groups called segments. Each segment has a small counter of its own. A lookup turns that counter's state into one of a short list of fully specified subvectors. The segment list and every subvector are fixed by parameters at elaboration. Any don't-care bits must be resolved to 0 or 1 before they go into the parameters.

The segment counters form a mixed-radix counter. Over one run the block presents every combination of segment subvectors exactly once, R patterns in total, where R is the product of the segment list lengths. When the column grouping was chosen so that each target pattern is one such combination, every target pattern appears during the run. A one-cycle done pulse marks the end of the run. The block then idles until it is restarted or reset.

Top module: `seg_tpg`

## Requirements
- R1: Bits [s*SEG_W +: SEG_W] of `pat_o` are driven only by segment s and equal entry k of that segment's list, where k is the segment's current state. Entry k sits at bits [(s*MAX_R+k)*SEG_W +: SEG_W] of `SEG_TAB`.
- R2: A segment whose list length is r only ever occupies states 0..r-1. It wraps from r-1 to 0, so it shows only its r listed subvectors.
- R3: Patterns advance in mixed-radix order. Segment 0 steps on every cycle where `valid_o` is high. Segment k steps only on a cycle where all lower segments wrap.
- R4: One run presents exactly R = product of all list lengths patterns with `valid_o` high, and no pattern repeats.
- R5: Every target pattern built from one subvector per segment appears during a run.
- R6: While `rst_ni` is low, all segments are at state 0 and `done_o` is 0. With the default parameters, `pat_o` reads 12'h501.
- R7: `valid_o` equals `en_i` in the same cycle as long as the run is unfinished and `start_i` is low. While `en_i` is low, the pattern holds.
- R8: `done_o` is high for exactly one cycle. That cycle comes right after the cycle in which the last combination (every segment at r-1) was valid. Afterwards `valid_o` stays low until a restart.
- R9: `start_i` returns every segment to state 0 and clears the finished state. During the start cycle `valid_o` is low and no step is taken, even when it falls on the last combination, and then no done pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Allow generation to advance |
| start_i | input | 1 | Synchronous restart of the run |
| pat_o | output | NUM_SEG*SEG_W | Current test pattern |
| valid_o | output | 1 | Pattern is presented this cycle |
| done_o | output | 1 | One-cycle end-of-run pulse |

## Verification
A restart and the final step of a run can fall in the same cycle. If they did, the final carry would raise done while the counters are being cleared. The bench provokes this by holding `start_i` high in exactly the cycle where the last combination is presented with `en_i` high. It then judges three things: `valid_o` is low in that cycle, no done pulse follows, and the first combination returns with `valid_o` high on the next cycle. Enable gaps in the middle of a run are also checked against the held pattern.

// File: rtl/seg_tpg_pkg.sv
package seg_tpg_pkg;
  function automatic int state_bits(input int r);
    return (r > 1) ? $clog2(r) : 1;
  endfunction
endpackage

// File: rtl/seg_tpg_segment.sv
module seg_tpg_segment #(
  parameter int SEG_W = 4,
  parameter int MAX_R = 4,
  parameter int R     = 4,
  parameter logic [MAX_R*SEG_W-1:0] TAB = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  output logic             wrap_o,
  output logic [SEG_W-1:0] sub_o
);
  localparam int SW = seg_tpg_pkg::state_bits(R);
  localparam logic [SW-1:0] LAST = SW'(R - 1);

  logic [SW-1:0] state_q;

  assign wrap_o = (state_q == LAST);
  assign sub_o  = TAB[state_q*SEG_W +: SEG_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= '0;
    else if (clr_i)  state_q <= '0;
    else if (adv_i)  state_q <= wrap_o ? '0 : state_q + 1'b1;
  end

  assert_state_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q <= LAST);
  assert_wrap_to_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && wrap_o && !clr_i) |=> (state_q == '0));
  assert_hold_when_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !clr_i) |=> $stable(state_q));
endmodule

// File: rtl/seg_tpg_ctrl.sv
module seg_tpg_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic start_i,
  input  logic carry_i,
  output logic step_o,
  output logic valid_o,
  output logic done_o
);
  logic fin_q, done_q;

  assign valid_o = en_i && !fin_q && !start_i;
  assign step_o  = valid_o;
  assign done_o  = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fin_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      fin_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= step_o && carry_i;
      if (step_o && carry_i) fin_q <= 1'b1;
    end
  end

  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_idle_after_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> !valid_o);
  assert_start_no_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_o);
endmodule

// File: rtl/seg_tpg.sv
module seg_tpg #(
  parameter int NUM_SEG = 3,
  parameter int SEG_W   = 4,
  parameter int MAX_R   = 4,
  parameter logic [NUM_SEG-1:0][7:0] SEG_R = {8'd3, 8'd2, 8'd4},
  parameter logic [NUM_SEG*MAX_R*SEG_W-1:0] SEG_TAB = 48'h03A5_00F0_8421
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     en_i,
  input  logic                     start_i,
  output logic [NUM_SEG*SEG_W-1:0] pat_o,
  output logic                     valid_o,
  output logic                     done_o
);
  localparam int TAB_W = MAX_R * SEG_W;

  logic [NUM_SEG:0]   adv;   // adv[NUM_SEG] is the carry out of the top segment
  logic [NUM_SEG-1:0] wrap;
  logic               step;

  assign adv[0] = step;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    localparam int RS = int'(SEG_R[g]);
    seg_tpg_segment #(
      .SEG_W(SEG_W), .MAX_R(MAX_R), .R(RS),
      .TAB(SEG_TAB[g*TAB_W +: TAB_W])
    ) u_seg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (start_i),
      .adv_i  (adv[g]),
      .wrap_o (wrap[g]),
      .sub_o  (pat_o[g*SEG_W +: SEG_W])
    );
    assign adv[g+1] = adv[g] && wrap[g];
  end

  seg_tpg_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .start_i (start_i),
    .carry_i (adv[NUM_SEG]),
    .step_o  (step),
    .valid_o (valid_o),
    .done_o  (done_o)
  );

  assert_valid_needs_en_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (en_i && !start_i));
  assert_done_not_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !valid_o);
endmodule

// File: tb/tb_seg_tpg.sv
module tb_seg_tpg;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        start_i = 1'b0;
  logic [11:0] pat_o;
  logic        valid_o, done_o;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk_i = ~clk_i;

  seg_tpg dut (.*);

  localparam logic [3:0] E0 [4] = '{4'h1, 4'h2, 4'h4, 4'h8};
  localparam logic [3:0] E1 [2] = '{4'h0, 4'hF};
  localparam logic [3:0] E2 [3] = '{4'h5, 4'hA, 4'h3};
  localparam int RTOT = 24;

  // target patterns and the run index where each is expected
  localparam logic [11:0] TGT [6] = '{12'h501, 12'h5F8, 12'hA02, 12'hAF4, 12'h304, 12'h3F8};
  localparam int TGT_IDX [6] = '{0, 7, 9, 14, 18, 23};

  function automatic logic [11:0] exp_pat(input int n);
    return {E2[(n / 8) % 3], E1[(n / 4) % 2], E0[n % 4]};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  logic [11:0] rec [0:31];
  int n_rec;

  initial begin
    #200000;
    n_err++; n_chk++;
    $display("FAIL watchdog act=0 exp=1");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int last_c;
    bit got_done;
    #12;
    chk(pat_o == 12'h501, "R6 reset pattern", pat_o, 12'h501);
    chk(done_o == 1'b0, "R6 reset done", done_o, 0);
    chk(valid_o == 1'b0, "R7 valid with en low", valid_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;

    // full run with an enable gap
    n_rec = 0; last_c = -1; got_done = 0;
    for (int c = 0; c < 40 && !got_done; c++) begin
      @(negedge clk_i);
      en_i = !(c >= 10 && c <= 12);
      #1;
      if (!en_i) begin
        chk(valid_o == 1'b0, "R7 gap valid", valid_o, 0);
        chk(pat_o == exp_pat(n_rec), "R7 gap hold", pat_o, exp_pat(n_rec));
      end
      if (valid_o) begin
        chk(pat_o == exp_pat(n_rec), "R1 R3 order", pat_o, exp_pat(n_rec));
        chk(pat_o[3:0] != 4'h0 && (pat_o[7:4] == 4'h0 || pat_o[7:4] == 4'hF) &&
            (pat_o[11:8] == 4'h5 || pat_o[11:8] == 4'hA || pat_o[11:8] == 4'h3),
            "R2 subvector set", pat_o, exp_pat(n_rec));
        for (int j = 0; j < n_rec; j++)
          if (rec[j] == pat_o) chk(1'b0, "R4 repeat", pat_o, 0);
        if (n_rec < 32) rec[n_rec] = pat_o;
        n_rec++;
        last_c = c;
      end
      if (done_o) begin
        got_done = 1;
        chk(n_rec == RTOT, "R4 count", n_rec, RTOT);
        chk(c == last_c + 1, "R8 done timing", c, last_c + 1);
        chk(valid_o == 1'b0, "R8 valid at done", valid_o, 0);
      end
    end
    chk(got_done, "R8 done seen", got_done, 1);

    for (int k = 0; k < 6; k++) begin
      bit found = 0;
      for (int j = 0; j < n_rec && j < 32; j++) if (rec[j] == TGT[k]) found = 1;
      chk(found, "R5 target present", TGT[k], TGT[k]);
      chk(exp_pat(TGT_IDX[k]) == TGT[k], "R5 target index", exp_pat(TGT_IDX[k]), TGT[k]);
    end

    for (int c = 0; c < 3; c++) begin
      @(negedge clk_i); #1;
      chk(done_o == 1'b0, "R8 single pulse", done_o, 0);
      chk(valid_o == 1'b0, "R8 idle after done", valid_o, 0);
    end

    // restart
    @(negedge clk_i); start_i = 1'b1; #1;
    chk(valid_o == 1'b0, "R9 valid during start", valid_o, 0);
    @(negedge clk_i); start_i = 1'b0; #1;
    chk(valid_o == 1'b1 && pat_o == exp_pat(0), "R9 restart first", pat_o, exp_pat(0));
    for (int n = 1; n < RTOT; n++) begin
      @(negedge clk_i); #1;
    end
    chk(valid_o == 1'b1 && pat_o == exp_pat(RTOT - 1), "R3 last combination", pat_o, exp_pat(RTOT - 1));
    // start collides with the final step
    start_i = 1'b1; #1;
    chk(valid_o == 1'b0, "R9 start on last", valid_o, 0);
    @(negedge clk_i); start_i = 1'b0; #1;
    chk(done_o == 1'b0, "R9 no done after start", done_o, 0);
    chk(valid_o == 1'b1 && pat_o == exp_pat(0), "R9 first after collision", pat_o, exp_pat(0));
    @(negedge clk_i); #1;
    chk(pat_o == exp_pat(1), "R3 step after collision", pat_o, exp_pat(1));
    @(negedge clk_i); #1;
    chk(pat_o == exp_pat(2), "R3 second step", pat_o, exp_pat(2));

    // asynchronous reset mid-run
    rst_ni = 1'b0; #1;
    chk(pat_o == 12'h501 && done_o == 1'b0, "R6 reset mid-run", pat_o, 12'h501);
    @(negedge clk_i); rst_ni = 1'b1; en_i = 1'b0;

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule